// File: doc/BRIEF.md
# ADC Control Sequencer with Self-Calibration

This block is the digital sequencer of a 10-bit successive-approximation converter. Once reset is released it runs a fixed-length self-calibration. Throughout that phase it holds the busy output high, ignores conversion requests and writes placeholder values into the result register at regular intervals. When calibration finishes, both the end-of-conversion flag and the error flag are set. The data register also holds an unread placeholder value at that point, so software is expected to read it once and clear both flags before it requests the first real conversion.

After calibration, a start pulse in the idle state begins a conversion of fixed length. The analog core is replaced by a stub input, which is captured as the result. Two write policies are available. With wait-for-read off, a finished result overwrites the register at once. If the previous value had not been read, the error flag records an overrun. With wait-for-read on, a finished result is parked while the previous value is still unread. Busy stays high until the register is read, and the parked result is then loaded. As a consequence, an unread calibration value stalls the first conversion for as long as the read does not happen. Each flag drives an interrupt request through its own enable.

Top module: `adc_ctrl_seq`

## Requirements
- R1: While rst_n is low: busy_o is 1, data_o is 0, both flags are 0 and both interrupt requests are 0, whatever the enables are.
- R2: After rst_n rises, busy_o stays 1 for exactly CAL_CYCLES + SYNC_STAGES clock cycles (default 40629 + 2) and then falls to 0.
- R3: start_i has no effect while busy_o is 1. This covers both calibration and a running conversion: it neither lengthens busy nor queues a second conversion.
- R4: During calibration the data register is loaded every 2^CAL_WR_LOG2 cycles with the low RES_W bits of the calibration cycle counter. With the defaults, data_o reads 687 when calibration ends.
- R5: On the cycle calibration ends, both eoc_flag_o and err_flag_o become 1, and the placeholder value remains unread.
- R6: A start_i sampled high while idle makes busy_o 1 for CONV_CYCLES cycles, starting at the next cycle. At the end, stub_res_i as sampled on the last cycle is loaded into data_o and eoc_flag_o is set.
- R7: With wait_rd_i at 1, a finished result is not written while the register is unread. busy_o stays 1 and data_o keeps its value indefinitely. The cycle after an rd_i pulse, data_o shows the parked result and busy_o falls to 0.
- R8: With wait_rd_i at 0, a result written over an unread value sets err_flag_o. A result written after an rd_i pulse leaves err_flag_o at 0.
- R9: A one-cycle pulse on eoc_clr_i or err_clr_i clears that flag. If a set condition occurs in the same cycle, the set takes priority and the flag stays 1.
- R10: eoc_irq_o equals eoc_flag_o AND eoc_ie_i, and err_irq_o equals err_flag_o AND err_ie_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| start_i | input | 1 | Conversion request, sampled while idle |
| wait_rd_i | input | 1 | 1 = hold new results until the previous one is read |
| rd_i | input | 1 | Read strobe of the data register |
| stub_res_i | input | 10 | Stand-in for the analog core's conversion result |
| eoc_clr_i | input | 1 | Clear pulse for the end-of-conversion flag |
| err_clr_i | input | 1 | Clear pulse for the overrun/error flag |
| eoc_ie_i | input | 1 | Interrupt enable for the end-of-conversion flag |
| err_ie_i | input | 1 | Interrupt enable for the error flag |
| busy_o | output | 1 | Calibration or conversion in progress |
| data_o | output | 10 | Result data register |
| eoc_flag_o | output | 1 | End-of-conversion flag |
| err_flag_o | output | 1 | Overrun/error flag |
| eoc_irq_o | output | 1 | End-of-conversion interrupt request |
| err_irq_o | output | 1 | Error interrupt request |

## Verification
A miscounting calibration counter shows up at the ports as a busy interval that is off by one or more cycles, or as a wrong final placeholder value in data_o. Both can be seen the moment busy falls. A corrupted unread marker shows up within one conversion, as a wrong err_flag_o or as a conversion that stalls or fails to stall in wait-for-read mode. A stuck-busy hold state appears as busy_o that never falls after a read, which the next sample catches.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_CAL  = 2'd0,
    ST_IDLE = 2'd1,
    ST_CONV = 2'd2,
    ST_HOLD = 2'd3
  } seq_state_e;
endpackage

// File: rtl/adc_seq_rstsync.sv
module adc_seq_rstsync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int CAL_CYCLES  = 40629,
  parameter int CONV_CYCLES = 12,
  parameter int CAL_WR_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             wait_rd_i,
  input  logic             rd_i,
  input  logic             unread_i,
  output logic             busy_o,
  output logic             in_cal_o,
  output logic             cal_end_o,
  output logic             wr_dummy_o,
  output logic             wr_direct_o,
  output logic             cap_hold_o,
  output logic             wr_held_o,
  output logic [RES_W-1:0] cal_pat_o
);
  localparam int CNT_W = (CAL_CYCLES > CONV_CYCLES) ? $clog2(CAL_CYCLES + 1) : $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0] CAL_LAST  = CNT_W'(CAL_CYCLES - 1);
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYCLES - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    cnt_en      = 1'b0;
    cal_end_o   = 1'b0;
    wr_dummy_o  = 1'b0;
    wr_direct_o = 1'b0;
    cap_hold_o  = 1'b0;
    wr_held_o   = 1'b0;
    case (state_q)
      ST_CAL: begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q + 1'b1;
        if (&cnt_q[CAL_WR_LOG2-1:0]) wr_dummy_o = 1'b1;
        if (cnt_q == CAL_LAST) begin
          cal_end_o = 1'b1;
          cnt_d     = '0;
          state_d   = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (start_i) begin
          cnt_en  = 1'b1;
          cnt_d   = '0;
          state_d = ST_CONV;
        end
      end
      ST_CONV: begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == CONV_LAST) begin
          cnt_d = '0;
          if (wait_rd_i && unread_i && !rd_i) begin
            cap_hold_o = 1'b1;
            state_d    = ST_HOLD;
          end else begin
            wr_direct_o = 1'b1;
            state_d     = ST_IDLE;
          end
        end
      end
      ST_HOLD: begin
        if (rd_i) begin
          wr_held_o = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CAL;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign in_cal_o  = (state_q == ST_CAL);
  assign cal_pat_o = cnt_q[RES_W-1:0];

  AST_CAL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(state_q == ST_CAL) |-> ($past(cnt_q) == CAL_LAST)); // R2
  AST_NO_START_IN_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CAL && cnt_q != CAL_LAST) |=> (state_q == ST_CAL)); // R3
  AST_HOLD_UNTIL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && !rd_i) |=> (state_q == ST_HOLD)); // R7
endmodule

// File: rtl/adc_seq_data.sv
module adc_seq_data #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_cal_i,
  input  logic             wait_rd_i,
  input  logic             rd_i,
  input  logic             wr_dummy_i,
  input  logic             wr_direct_i,
  input  logic             cap_hold_i,
  input  logic             wr_held_i,
  input  logic [RES_W-1:0] cal_pat_i,
  input  logic [RES_W-1:0] stub_res_i,
  output logic [RES_W-1:0] data_o,
  output logic             unread_o,
  output logic             overrun_o
);
  logic [RES_W-1:0] data_q, data_d, hold_q;
  logic             data_en;
  logic             unread_q, unread_d;

  always_comb begin
    data_en = wr_dummy_i | wr_direct_i | wr_held_i;
    if (wr_dummy_i)       data_d = cal_pat_i;
    else if (wr_held_i)   data_d = hold_q;
    else                  data_d = stub_res_i;
    if (data_en)          unread_d = 1'b1;
    else if (rd_i)        unread_d = 1'b0;
    else                  unread_d = unread_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      hold_q   <= '0;
      unread_q <= 1'b0;
    end else begin
      if (data_en)    data_q <= data_d;
      if (cap_hold_i) hold_q <= stub_res_i;
      unread_q <= unread_d;
    end
  end

  assign data_o    = data_q;
  assign unread_o  = unread_q;
  assign overrun_o = wr_direct_i & unread_q & ~rd_i;

  AST_WAIT_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_cal_i && wait_rd_i && unread_q && !rd_i) |=> $stable(data_q)); // R7
endmodule

// File: rtl/adc_seq_flag.sv
module adc_seq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic ie_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q, flag_d, flag_en;

  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & ie_i;

  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(flag_q)); // R9
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q); // R9
endmodule

// File: rtl/adc_ctrl_seq.sv
module adc_ctrl_seq #(
  parameter int RES_W       = 10,
  parameter int CAL_CYCLES  = 40629,
  parameter int CONV_CYCLES = 12,
  parameter int CAL_WR_LOG2 = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             wait_rd_i,
  input  logic             rd_i,
  input  logic [RES_W-1:0] stub_res_i,
  input  logic             eoc_clr_i,
  input  logic             err_clr_i,
  input  logic             eoc_ie_i,
  input  logic             err_ie_i,
  output logic             busy_o,
  output logic [RES_W-1:0] data_o,
  output logic             eoc_flag_o,
  output logic             err_flag_o,
  output logic             eoc_irq_o,
  output logic             err_irq_o
);
  localparam int NUM_FLAGS = 2;
  localparam int EOC_IDX   = 0;
  localparam int ERR_IDX   = 1;

  logic             rst_sync_n;
  logic             in_cal, cal_end, wr_dummy, wr_direct, cap_hold, wr_held;
  logic             unread, overrun;
  logic [RES_W-1:0] cal_pat;
  logic [NUM_FLAGS-1:0] f_set, f_clr, f_ie, f_flag, f_irq;

  adc_seq_rstsync #(.SYNC_STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  adc_seq_fsm #(
    .RES_W(RES_W), .CAL_CYCLES(CAL_CYCLES),
    .CONV_CYCLES(CONV_CYCLES), .CAL_WR_LOG2(CAL_WR_LOG2)
  ) u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .start_i(start_i), .wait_rd_i(wait_rd_i),
    .rd_i(rd_i), .unread_i(unread), .busy_o(busy_o), .in_cal_o(in_cal),
    .cal_end_o(cal_end), .wr_dummy_o(wr_dummy), .wr_direct_o(wr_direct),
    .cap_hold_o(cap_hold), .wr_held_o(wr_held), .cal_pat_o(cal_pat)
  );

  adc_seq_data #(.RES_W(RES_W)) u_data (
    .clk(clk), .rst_n(rst_sync_n), .in_cal_i(in_cal), .wait_rd_i(wait_rd_i),
    .rd_i(rd_i), .wr_dummy_i(wr_dummy), .wr_direct_i(wr_direct),
    .cap_hold_i(cap_hold), .wr_held_i(wr_held), .cal_pat_i(cal_pat),
    .stub_res_i(stub_res_i), .data_o(data_o), .unread_o(unread),
    .overrun_o(overrun)
  );

  always_comb begin
    f_set[EOC_IDX] = cal_end | wr_direct | wr_held;
    f_set[ERR_IDX] = cal_end | overrun;
    f_clr[EOC_IDX] = eoc_clr_i;
    f_clr[ERR_IDX] = err_clr_i;
    f_ie[EOC_IDX]  = eoc_ie_i;
    f_ie[ERR_IDX]  = err_ie_i;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
      adc_seq_flag u_flag (
        .clk(clk), .rst_n(rst_sync_n), .set_i(f_set[gi]), .clr_i(f_clr[gi]),
        .ie_i(f_ie[gi]), .flag_o(f_flag[gi]), .irq_o(f_irq[gi])
      );
    end
  endgenerate

  assign eoc_flag_o = f_flag[EOC_IDX];
  assign err_flag_o = f_flag[ERR_IDX];
  assign eoc_irq_o  = f_irq[EOC_IDX];
  assign err_irq_o  = f_irq[ERR_IDX];

  AST_CAL_END_FLAGS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(in_cal) |-> (eoc_flag_o && err_flag_o && unread)); // R5
  AST_ERR_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(err_flag_o) && !$past(in_cal)) |-> $past(unread)); // R8
endmodule

// File: tb/adc_ctrl_seq_tb.sv
`timescale 1ns/1ps
module adc_ctrl_seq_tb;
  localparam int RES_W   = 10;
  localparam int CAL     = 40629;
  localparam int CONV    = 12;
  localparam int SYNC    = 2;
  localparam int CAL_VAL = 687;

  logic clk = 1'b0;
  logic rst_n, start_i, wait_rd_i, rd_i, eoc_clr_i, err_clr_i, eoc_ie_i, err_ie_i;
  logic [RES_W-1:0] stub_res_i, data_o;
  logic busy_o, eoc_flag_o, err_flag_o, eoc_irq_o, err_irq_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  adc_ctrl_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .wait_rd_i(wait_rd_i),
    .rd_i(rd_i), .stub_res_i(stub_res_i), .eoc_clr_i(eoc_clr_i),
    .err_clr_i(err_clr_i), .eoc_ie_i(eoc_ie_i), .err_ie_i(err_ie_i),
    .busy_o(busy_o), .data_o(data_o), .eoc_flag_o(eoc_flag_o),
    .err_flag_o(err_flag_o), .eoc_irq_o(eoc_irq_o), .err_irq_o(err_irq_o)
  );

  // {wait_rd, read_first, expected err, stub value}
  localparam logic [12:0] VEC [0:5] = '{
    {1'b0, 1'b0, 1'b1, 10'h155},
    {1'b0, 1'b1, 1'b0, 10'h2AA},
    {1'b1, 1'b1, 1'b0, 10'h3FF},
    {1'b0, 1'b0, 1'b1, 10'h000},
    {1'b1, 1'b1, 1'b0, 10'h001},
    {1'b0, 1'b1, 1'b0, 10'h200}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_rd();
    rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  task automatic clear_flags();
    eoc_clr_i = 1'b1; err_clr_i = 1'b1;
    @(negedge clk);
    eoc_clr_i = 1'b0; err_clr_i = 1'b0;
  endtask

  // start held 3 cycles; returns number of samples until busy falls
  task automatic run_conv(input logic [RES_W-1:0] val, output int n);
    stub_res_i = val;
    start_i = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 3) start_i = 1'b0;
    end while (busy_o && n < 1000);
    start_i = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000 && !done) begin
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected below 190000 cycles", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; start_i = 1'b0; wait_rd_i = 1'b0; rd_i = 1'b0;
    eoc_clr_i = 1'b0; err_clr_i = 1'b0; eoc_ie_i = 1'b1; err_ie_i = 1'b1;
    stub_res_i = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy_o, 1);
    chk("R1 data in reset", data_o, 0);
    chk("R1 flags in reset", {eoc_flag_o, err_flag_o}, 0);
    chk("R1 irqs in reset", {eoc_irq_o, err_irq_o}, 0);

    rst_n = 1'b1;
    err_ie_i = 1'b0;
    n = 0;
    while (busy_o) begin
      @(negedge clk);
      n++;
      if (n == 100) start_i = 1'b1;   // R3: request during calibration
      if (n == 103) start_i = 1'b0;
    end
    chk("R2 calibration length", n, CAL + SYNC);
    @(negedge clk);
    chk("R3 start in calibration ignored", busy_o, 0);
    chk("R4 calibration placeholder", data_o, CAL_VAL);
    chk("R5 eoc after calibration", eoc_flag_o, 1);
    chk("R5 err after calibration", err_flag_o, 1);
    chk("R10 eoc irq enabled", eoc_irq_o, 1);
    chk("R10 err irq disabled", err_irq_o, 0);
    err_ie_i = 1'b1;
    #1;
    chk("R10 err irq enabled", err_irq_o, 1);

    clear_flags();
    chk("R9 flags cleared", {eoc_flag_o, err_flag_o}, 0);

    // R7: unread calibration value stalls the first conversion
    wait_rd_i = 1'b1;
    stub_res_i = 10'h1C3;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (CONV + 30) @(negedge clk);
    chk("R7 stalled busy", busy_o, 1);
    chk("R7 stalled data", data_o, CAL_VAL);
    chk("R7 stalled eoc", eoc_flag_o, 0);
    rd_i = 1'b1;
    #1;
    chk("R7 old value at read", data_o, CAL_VAL);
    @(negedge clk);
    rd_i = 1'b0;
    chk("R7 parked result", data_o, 10'h1C3);
    chk("R7 busy released", busy_o, 0);
    chk("R7 eoc set", eoc_flag_o, 1);
    chk("R7 no overrun", err_flag_o, 0);

    for (int i = 0; i < 6; i++) begin
      clear_flags();
      wait_rd_i = VEC[i][12];
      if (VEC[i][11]) pulse_rd();
      run_conv(VEC[i][9:0], n);
      chk($sformatf("R6 busy length vec%0d", i), n, CONV + 1);
      chk($sformatf("R6 data vec%0d", i), data_o, VEC[i][9:0]);
      chk($sformatf("R6 eoc vec%0d", i), eoc_flag_o, 1);
      chk($sformatf("R8 err vec%0d", i), err_flag_o, VEC[i][10]);
      chk($sformatf("R10 irqs vec%0d", i), {eoc_irq_o, err_irq_o}, {1'b1, VEC[i][10]});
    end

    // R9: set wins over clear in the same cycle (overrun also sets err)
    clear_flags();
    wait_rd_i = 1'b0;
    stub_res_i = 10'h0F0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (CONV - 1) @(negedge clk);
    chk("R9 eoc before end", eoc_flag_o, 0);
    eoc_clr_i = 1'b1; err_clr_i = 1'b1;
    @(negedge clk);
    eoc_clr_i = 1'b0; err_clr_i = 1'b0;
    chk("R9 eoc set wins", eoc_flag_o, 1);
    chk("R9 err set wins", err_flag_o, 1);
    chk("R6 data set-wins case", data_o, 10'h0F0);

    // R1: asynchronous reset mid-run
    #1 rst_n = 1'b0;
    #1;
    chk("R1 async reset busy", busy_o, 1);
    chk("R1 async reset data", data_o, 0);
    chk("R1 async reset flags", {eoc_flag_o, err_flag_o}, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule